// File: doc/BRIEF.md
# Multi-table lookup interpolator

This block keeps one shared table memory of 4096 words, each 27 bits wide. The memory is divided into five conversion tables. A host loads the words through a simple write port. Each lookup request carries a 3-bit table selector and a 20-bit normalized input. The high bits of the input pick an entry. The low bits weight a straight-line blend between that entry and the next one. The blended 27-bit value comes back a fixed two clocks after the request is issued, together with a one-cycle valid pulse.

Two selectors lead to 512-entry tables: one maps pitch-oscillator period to hand distance, the other maps volume-oscillator period to hand distance. The remaining selectors lead to 1024-entry tables: distance to note (a 6.18 fixed-point value whose integer part is a MIDI note number), note to the phase step that a 24-bit audio phase accumulator adds each sample, and distance to a volume multiplier. A lookup never reads in the same cycle as a host write. A request that meets a write waits in a one-deep holding slot and issues in the first cycle without a write. The requester must not present a new request while one is held.

Top module: `lerp_table_unit`

## Requirements
- R1: A cycle with `wr_en` high stores `wr_data` at word `wr_addr`. A later lookup with a zero fraction that lands on that word returns exactly the stored value.
- R2: Selectors 3'b000 and 3'b001 address a 512-entry table. The entry address is {sel, x[19:11]} and the 11-bit weight is x[10:0].
- R3: A selector with sel[2:1] not 2'b00 addresses a 1024-entry table at {sel[2:1], x[19:10]}. The weight is x[9:0] shifted left by one (11 bits), and sel[0] has no effect on the result.
- R4: The result is a + floor((b − a) × w / 2048). Here a is the selected entry, b is the following entry and w is the 11-bit weight. This holds whether b is above or below a, so the result always lies between a and b.
- R5: When the selected entry is the last one of its table (index all ones), b equals a. No lookup reads a word outside the selected table.
- R6: An issued request gives `res_valid` high for exactly one cycle, two rising edges after the edge that issues it. Requests may be issued on consecutive cycles, and each one gets its own result in order.
- R7: A request presented while `wr_en` is high is not issued in that cycle. It is issued in the first following cycle with `wr_en` low, so it sees every word written up to then.
- R8: While `rst_n` is low and after it is released, `res_valid` and `res_data` are zero and no request is held.
- R9: Entries at the extremes 0 and 27'h7FFFFFF blend without wrap-around, in both the rising and the falling direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 12 | Host word address |
| wr_data | input | 27 | Host word value |
| req_valid | input | 1 | Lookup request strobe |
| req_sel | input | 3 | Table selector |
| req_x | input | 20 | Normalized input fraction |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 27 | Interpolated result |

## Verification
On every cycle the assertions check the timing and address rules. A write cycle never issues a read. A held request is released once the write ends. Each issued request is followed by exactly one result two edges later, and no result appears without one. The two words read are always the same word or neighbours inside one table, and each result lies between the two words it was blended from. Only the bench scenarios can show that the words chosen and the blend value are numerically right. They compare results against a separately kept image of the memory: across both table sizes, at the last entries, at full-scale values, on back-to-back requests, and when a request meets a write to the very word it reads.

// File: rtl/lerp_pkg.sv
package lerp_pkg;
  localparam int DATA_W      = 27;
  localparam int ADDR_W      = 12;
  localparam int IN_W        = 20;
  localparam int SEL_W       = 3;
  localparam int SMALL_IDX_W = 9;
  localparam int LARGE_IDX_W = 10;
  localparam int FRAC_W      = IN_W - SMALL_IDX_W;
  localparam int NUM_BANKS   = 2;
  localparam int BANK_WORDS  = (1 << ADDR_W) / NUM_BANKS;
  localparam int BANK_AW     = ADDR_W - 1;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [FRAC_W-1:0] frac_t;

  // Tables of 1024 entries are chosen by any selector above 3'b001.
  function automatic logic is_large(input logic [SEL_W-1:0] sel);
    return sel[SEL_W-1:SEL_W-2] != 2'b00;
  endfunction

  function automatic addr_t entry_addr(input logic [SEL_W-1:0] sel, input logic [IN_W-1:0] x);
    if (is_large(sel)) return {sel[SEL_W-1:SEL_W-2], x[IN_W-1 -: LARGE_IDX_W]};
    return {sel, x[IN_W-1 -: SMALL_IDX_W]};
  endfunction

  function automatic logic at_last(input logic [SEL_W-1:0] sel, input logic [IN_W-1:0] x);
    if (is_large(sel)) return &x[IN_W-1 -: LARGE_IDX_W];
    return &x[IN_W-1 -: SMALL_IDX_W];
  endfunction

  // Weight is always normalized to FRAC_W bits.
  function automatic frac_t weight(input logic [SEL_W-1:0] sel, input logic [IN_W-1:0] x);
    if (is_large(sel)) return {x[IN_W-LARGE_IDX_W-1:0], 1'b0};
    return x[FRAC_W-1:0];
  endfunction

  function automatic word_t blend(input word_t a, input word_t b, input frac_t w);
    logic signed [DATA_W:0]          diff;
    logic signed [DATA_W+FRAC_W+1:0] prod;
    logic signed [DATA_W+FRAC_W+1:0] step;
    diff = $signed({1'b0, b}) - $signed({1'b0, a});
    prod = diff * $signed({1'b0, w});
    step = prod >>> FRAC_W;
    return a + step[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/lerp_bank.sv
module lerp_bank #(
  parameter int WORDS = 2048,
  parameter int W     = 27,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lerp_addr_gen.sv
module lerp_addr_gen
  import lerp_pkg::*;
(
  input  logic [SEL_W-1:0]   sel,
  input  logic [IN_W-1:0]    x,
  output addr_t              addr_a,
  output addr_t              addr_b,
  output logic               last,
  output logic               a_odd,
  output logic [BANK_AW-1:0] even_raddr,
  output logic [BANK_AW-1:0] odd_raddr,
  output frac_t              w
);
  always_comb begin
    addr_a = entry_addr(sel, x);
    last   = at_last(sel, x);
    addr_b = last ? addr_a : addr_a + addr_t'(1);
    a_odd  = addr_a[0];
    w      = weight(sel, x);
    // Neighbouring words always sit in opposite banks.
    even_raddr = a_odd ? addr_b[ADDR_W-1:1] : addr_a[ADDR_W-1:1];
    odd_raddr  = a_odd ? addr_a[ADDR_W-1:1] : addr_b[ADDR_W-1:1];
  end
endmodule

// File: rtl/lerp_blend.sv
module lerp_blend
  import lerp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_vld,
  input  word_t a,
  input  word_t b,
  input  frac_t w,
  output logic  out_vld,
  output word_t out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_data <= blend(a, b, w);
    end
  end
endmodule

// File: rtl/lerp_table_unit.sv
module lerp_table_unit
  import lerp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [IN_W-1:0]   req_x,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);
  // Holding slot for a request that met a write.
  logic             held;
  logic [SEL_W-1:0] held_sel;
  logic [IN_W-1:0]  held_x;

  logic             issue_fire;
  logic             issue_large;
  logic [SEL_W-1:0] issue_sel;
  logic [IN_W-1:0]  issue_x;

  assign issue_sel   = held ? held_sel : req_sel;
  assign issue_x     = held ? held_x : req_x;
  assign issue_fire  = (held | req_valid) & ~wr_en;
  assign issue_large = is_large(issue_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      held_sel <= '0;
      held_x   <= '0;
    end else if (wr_en) begin
      if (req_valid && !held) begin
        held     <= 1'b1;
        held_sel <= req_sel;
        held_x   <= req_x;
      end
    end else begin
      held <= 1'b0;
    end
  end

  addr_t              addr_a, addr_b;
  logic               last, a_odd;
  logic [BANK_AW-1:0] even_raddr, odd_raddr;
  frac_t              w;

  lerp_addr_gen u_addr (
    .sel        (issue_sel),
    .x          (issue_x),
    .addr_a     (addr_a),
    .addr_b     (addr_b),
    .last       (last),
    .a_odd      (a_odd),
    .even_raddr (even_raddr),
    .odd_raddr  (odd_raddr),
    .w          (w)
  );

  logic [BANK_AW-1:0] bank_raddr [NUM_BANKS];
  word_t              bank_q     [NUM_BANKS];
  assign bank_raddr[0] = even_raddr;
  assign bank_raddr[1] = odd_raddr;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    lerp_bank #(.WORDS(BANK_WORDS), .W(DATA_W)) u_bank (
      .clk   (clk),
      .we    (wr_en && (wr_addr[0] == 1'(g))),
      .waddr (wr_addr[ADDR_W-1:1]),
      .wdata (wr_data),
      .re    (issue_fire),
      .raddr (bank_raddr[g]),
      .rdata (bank_q[g])
    );
  end

  // Stage 1: bank words are registered; these flags travel with them.
  logic  s1_vld, s1_a_odd, s1_last;
  frac_t s1_w;
  word_t s1_a, s1_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_a_odd <= 1'b0;
      s1_last  <= 1'b0;
      s1_w     <= '0;
    end else begin
      s1_vld <= issue_fire;
      if (issue_fire) begin
        s1_a_odd <= a_odd;
        s1_last  <= last;
        s1_w     <= w;
      end
    end
  end

  assign s1_a = s1_a_odd ? bank_q[1] : bank_q[0];
  assign s1_b = s1_last ? s1_a : (s1_a_odd ? bank_q[0] : bank_q[1]);

  lerp_blend u_blend (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (s1_vld),
    .a        (s1_a),
    .b        (s1_b),
    .w        (s1_w),
    .out_vld  (res_valid),
    .out_data (res_data)
  );
endmodule

// File: rtl/lerp_table_unit_chk.sv
module lerp_table_unit_chk
  import lerp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              req_valid,
  input logic              issue_fire,
  input logic              issue_large,
  input addr_t             addr_a,
  input addr_t             addr_b,
  input word_t             s1_a,
  input word_t             s1_b,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data
);
  AST_WRITE_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !issue_fire); // R7
  AST_HELD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wr_en) |=> (wr_en || issue_fire)); // R7
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> ##2 res_valid); // R6
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(issue_fire, 2)); // R6
  AST_NEIGHBOUR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> (addr_b == addr_a) || (addr_b == addr_a + addr_t'(1))); // R5
  AST_STAY_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> (issue_large ? (addr_b[ADDR_W-1:ADDR_W-2] == addr_a[ADDR_W-1:ADDR_W-2])
                                : (addr_b[ADDR_W-1:ADDR_W-3] == addr_a[ADDR_W-1:ADDR_W-3]))); // R5
  AST_RESULT_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_data >= (($past(s1_a) < $past(s1_b)) ? $past(s1_a) : $past(s1_b))) &&
                   (res_data <= (($past(s1_a) < $past(s1_b)) ? $past(s1_b) : $past(s1_a))))); // R4
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !res_valid && (res_data == '0)); // R8
endmodule

bind lerp_table_unit lerp_table_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .req_valid   (req_valid),
  .issue_fire  (issue_fire),
  .issue_large (issue_large),
  .addr_a      (addr_a),
  .addr_b      (addr_b),
  .s1_a        (s1_a),
  .s1_b        (s1_b),
  .res_valid   (res_valid),
  .res_data    (res_data)
);

// File: tb/test_lerp_table_unit.sv
`timescale 1ns/1ps
module test_lerp_table_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [26:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_sel = '0;
  logic [19:0] req_x = '0;
  logic        res_valid;
  logic [26:0] res_data;

  always #2 clk = ~clk;

  lerp_table_unit i_lerp_table_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_sel(req_sel), .req_x(req_x),
    .res_valid(res_valid), .res_data(res_data)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [26:0] image [4096];
  int unsigned seed = 32'h1234_5678;

  task automatic check(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Independent model: table geometry and floor-rounded blend.
  function automatic longint predict(input logic [2:0] sel, input logic [19:0] x);
    int base, idx, top, wt;
    longint a, b;
    if (sel >= 3'd2) begin
      base = int'(sel[2:1]) * 1024; idx = int'(x) / 1024; top = 1023; wt = (int'(x) % 1024) * 2;
    end else begin
      base = int'(sel) * 512; idx = int'(x) / 2048; top = 511; wt = int'(x) % 2048;
    end
    a = longint'(image[base + idx]);
    b = (idx == top) ? a : longint'(image[base + idx + 1]);
    if (b >= a) return a + ((b - a) * wt) / 2048;
    return a - (((a - b) * wt + 2047) / 2048);
  endfunction

  task automatic write_word(input int addr, input logic [26:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 12'(addr); wr_data = val;
    image[addr] = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input string tag, input logic [2:0] sel, input logic [19:0] x);
    longint exp;
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_x = x;
    exp = predict(sel, x);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R6 no early valid"}, longint'(res_valid), 0);
    @(negedge clk);
    check({tag, " R6 valid"}, longint'(res_valid), 1);
    check(tag, longint'(res_data), exp);
    @(negedge clk);
    check({tag, " R6 pulse ends"}, longint'(res_valid), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R8 valid in reset", longint'(res_valid), 0);
    check("R8 data in reset", longint'(res_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 valid after reset", longint'(res_valid), 0);
    check("R8 data after reset", longint'(res_data), 0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < 4096; a++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 12'(a);
      wr_data = 27'((a * 32'd2654435) ^ (a << 14) ^ 32'h5A5A5);
      image[a] = wr_data;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_exact();
    lookup("R1 exact sel0", 3'd0, 20'(17 << 11));
    write_word(12'h123 + 0, 27'h4321ABC);
    lookup("R1 overwrite sel0", 3'd0, 20'(12'h123 << 11));
    lookup("R1 exact sel6", 3'd6, 20'(700 << 10));
  endtask

  task automatic t_small();
    lookup("R2 R4 sel0 mid", 3'd0, 20'h12345);
    lookup("R2 R4 sel1 low", 3'd1, 20'h00401);
    lookup("R2 R4 sel1 high frac", 3'd1, 20'hABFFF);
    lookup("R2 R4 sel0 odd entry", 3'd0, 20'h00FFF);
  endtask

  task automatic t_large();
    lookup("R3 R4 sel2", 3'd2, 20'h3C2E1);
    lookup("R3 sel3 ignores bit0", 3'd3, 20'h3C2E1);
    lookup("R3 R4 sel4", 3'd4, 20'h80001);
    lookup("R3 sel5 ignores bit0", 3'd5, 20'h80001);
    lookup("R3 R4 sel7", 3'd7, 20'hF03FF);
  endtask

  task automatic t_last();
    lookup("R5 last small sel0", 3'd0, 20'hFFFFF);
    lookup("R5 last small sel1", 3'd1, 20'hFFC00);
    lookup("R5 last large sel2", 3'd2, 20'hFFFFF);
    lookup("R5 last large sel7", 3'd7, 20'hFFE00);
  endtask

  task automatic t_full();
    write_word(512 + 5, 27'h0);
    write_word(512 + 6, 27'h7FFFFFF);
    write_word(512 + 7, 27'h0);
    lookup("R9 rising full scale", 3'd1, 20'((5 << 11) | 1024));
    check("R9 rising value", longint'(res_data), 64'h3FFFFFF);
    lookup("R9 falling full scale", 3'd1, 20'((6 << 11) | 2047));
    lookup("R9 falling half", 3'd1, 20'((6 << 11) | 1024));
  endtask

  // A request meets n_wr write cycles; the first write hits the word it reads.
  task automatic t_collide(input int n_wr);
    longint exp;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 12'd1030; wr_data = 27'h1357BDF;
    image[1030] = 27'h1357BDF;
    req_valid = 1'b1; req_sel = 3'd2; req_x = 20'(6 << 10);
    exp = 64'h1357BDF;
    for (int i = 1; i < n_wr; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      wr_addr = 12'(3000 + i); wr_data = 27'(i); image[3000 + i] = 27'(i);
      check("R7 held while writing", longint'(res_valid), 0);
    end
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R7 no result after write", longint'(res_valid), 0);
    @(negedge clk);
    check("R7 delayed, not yet", longint'(res_valid), 0);
    @(negedge clk);
    check("R7 delayed valid", longint'(res_valid), 1);
    check("R7 sees new word", longint'(res_data), exp);
    @(negedge clk);
    check("R7 pulse ends", longint'(res_valid), 0);
  endtask

  task automatic t_stream();
    logic [19:0] xs [3] = '{20'h11111, 20'h7ABCD, 20'hC0FFE};
    logic [2:0]  ss [3] = '{3'd0, 3'd4, 3'd1};
    longint      ex [3];
    for (int i = 0; i < 3; i++) ex[i] = predict(ss[i], xs[i]);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R6 stream valid", longint'(res_valid), 1);
        check("R6 stream data", longint'(res_data), ex[i-2]);
      end
      req_valid = (i < 3);
      if (i < 3) begin req_sel = ss[i]; req_x = xs[i]; end
    end
    @(negedge clk);
    check("R6 stream ends", longint'(res_valid), 0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      lookup("R4 random", 3'(seed >> 29), 20'(seed >> 7));
    end
  endtask

  initial begin
    t_reset();
    t_fill();
    t_exact();
    t_small();
    t_large();
    t_last();
    t_full();
    t_collide(1);
    t_collide(3);
    t_stream();
    t_random();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule